// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides an input clock by a programmable ratio N and emits one single-cycle pulse per N input cycles. It is meant for the feedback path of a frequency synthesizer. The ratio is built by pulse swallowing. A dual-modulus prescaler divides by P+1 or by P. A swallow counter sets how many prescaler periods use the longer modulus. A main counter sets how many prescaler periods make up one output cycle. The resulting ratio is N = P·B + A.

The prescaler pair is chosen by one select input: 8/9 or 32/33. The swallow value A and the main value B come in on parallel inputs. They are sampled only at the boundary between output cycles, so a reprogramming never produces a truncated or stretched output cycle. Values outside the legal range are clamped and reported on a configuration-error output. Illegal values are B below 3, or A above B.

Top module: `pswl_divider`

## Requirements
- R1: While `rst_ni` is low, and until the first configuration is loaded, `div_o` and `cfg_err_o` are 0.
- R2: With a legal configuration (3 ≤ B, A ≤ B), consecutive rising edges of `div_o` are exactly P·B + A input cycles apart. P is 8 when `wide_i` is 0 and 32 when `wide_i` is 1. Each output cycle consists of B prescaler periods, and the first A of them are P+1 cycles long.
- R3: Every `div_o` pulse is high for exactly one input-clock cycle.
- R4: The first rising clock edge with `rst_ni` high loads the configuration. `div_o` rises on the N-th clock edge after that load edge.
- R5: When A > B, `cfg_err_o` is 1 for that configuration and A is treated as equal to B. The spacing is then (P+1)·B.
- R6: When B < 3, `cfg_err_o` is 1 and B is treated as 3. A is then clamped to 3 if it is larger.
- R7: New values on `wide_i`, `swallow_i` or `main_i` are sampled only on the clock edge where `div_o` rises, or on the load edge. The output cycle in progress keeps its old ratio.
- R8: `cfg_err_o` describes the configuration latched at the most recent boundary. It changes only on an edge where `div_o` rises, or on the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wide_i | input | 1 | Prescaler pair select: 0 for 8/9, 1 for 32/33 |
| swallow_i | input | 5 | Swallow count A (0 to 31) |
| main_i | input | 13 | Main count B (3 to 8191 legal) |
| div_o | output | 1 | One-cycle pulse per N input cycles |
| cfg_err_o | output | 1 | Latched configuration was clamped |

## Verification
The assertions check several properties on every cycle. The swallow count never exceeds the main count. The prescaler counter stays below its largest modulus. Output pulses never last two cycles. The error flag moves only on an output-cycle boundary. The bench's measured pulse spacings are what show the division ratio itself, the clamping of illegal A and B values, the latency from reset release, and that reprogramming lands on the following cycle and not the current one. The bench sweeps B and A densely with the 8/9 pair and samples the 32/33 pair.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
    localparam int unsigned SWALLOW_W  = 5;
    localparam int unsigned MAIN_W     = 13;
    localparam int unsigned P_SMALL    = 8;
    localparam int unsigned P_LARGE    = 32;
    localparam int unsigned MAIN_FLOOR = 3;
endpackage

// File: rtl/pswl_cfg_clamp.sv
module pswl_cfg_clamp #(
    parameter int unsigned A_W   = pswl_pkg::SWALLOW_W,
    parameter int unsigned B_W   = pswl_pkg::MAIN_W,
    parameter int unsigned FLOOR = pswl_pkg::MAIN_FLOOR
) (
    input  logic [A_W-1:0] swallow_i,
    input  logic [B_W-1:0] main_i,
    output logic [A_W-1:0] a_eff_o,
    output logic [B_W-1:0] b_eff_o,
    output logic           bad_o
);
    logic [B_W-1:0] a_wide;
    logic [B_W-1:0] b_fix;
    logic           b_low;
    logic           a_big;

    always_comb begin
        a_wide  = B_W'(swallow_i);
        b_low   = main_i < B_W'(FLOOR);
        b_fix   = b_low ? B_W'(FLOOR) : main_i;
        a_big   = a_wide > main_i;
        a_eff_o = (a_wide > b_fix) ? A_W'(b_fix) : swallow_i;
        b_eff_o = b_fix;
        bad_o   = b_low || a_big;
    end
endmodule

// File: rtl/pswl_prescaler.sv
module pswl_prescaler #(
    parameter int unsigned P_LO = pswl_pkg::P_SMALL,
    parameter int unsigned P_HI = pswl_pkg::P_LARGE
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic hi_i,
    input  logic plus1_i,
    output logic tick_o
);
    localparam int unsigned CW = $clog2(P_HI + 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } presc_t;

    presc_t        st_d, st_q;
    logic [CW-1:0] end_cnt;

    always_comb begin
        end_cnt = (hi_i ? CW'(P_HI - 1) : CW'(P_LO - 1)) + CW'(plus1_i);
        tick_o  = run_i && (st_q.cnt == end_cnt);
        st_d    = st_q;
        if (!run_i || tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_presc_range_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (st_q.cnt <= CW'(P_HI)));
endmodule

// File: rtl/pswl_swallow_main.sv
module pswl_swallow_main #(
    parameter int unsigned A_W = pswl_pkg::SWALLOW_W,
    parameter int unsigned B_W = pswl_pkg::MAIN_W
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           tick_i,
    input  logic [A_W-1:0] a_eff_i,
    input  logic [B_W-1:0] b_eff_i,
    input  logic           hi_cfg_i,
    input  logic           err_cfg_i,
    output logic           run_o,
    output logic           hi_o,
    output logic           plus1_o,
    output logic           div_o,
    output logic           err_o
);
    typedef struct packed {
        logic           idle;
        logic [A_W-1:0] aq;
        logic [B_W-1:0] bq;
        logic           hi;
        logic           err;
        logic           div;
    } cnt_t;

    cnt_t st_d, st_q;
    logic boundary;

    always_comb begin
        st_d     = st_q;
        st_d.div = 1'b0;
        boundary = st_q.idle || (tick_i && (st_q.bq == B_W'(1)));
        if (boundary) begin
            st_d.idle = 1'b0;
            st_d.aq   = a_eff_i;
            st_d.bq   = b_eff_i;
            st_d.hi   = hi_cfg_i;
            st_d.err  = err_cfg_i;
            st_d.div  = !st_q.idle;
        end else if (tick_i) begin
            st_d.bq = st_q.bq - B_W'(1);
            if (st_q.aq != '0) begin
                st_d.aq = st_q.aq - A_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.idle <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o   = !st_q.idle;
    assign hi_o    = st_q.hi;
    assign plus1_o = st_q.aq != '0;
    assign div_o   = st_q.div;
    assign err_o   = st_q.err;

    assert_swallow_le_main_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.idle |-> (B_W'(st_q.aq) <= st_q.bq));

    assert_main_nonzero_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.idle |-> (st_q.bq != '0));

    assert_single_pulse_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.div |=> !st_q.div);
endmodule

// File: rtl/pswl_divider.sv
module pswl_divider #(
    parameter int unsigned A_W   = pswl_pkg::SWALLOW_W,
    parameter int unsigned B_W   = pswl_pkg::MAIN_W,
    parameter int unsigned P_LO  = pswl_pkg::P_SMALL,
    parameter int unsigned P_HI  = pswl_pkg::P_LARGE,
    parameter int unsigned FLOOR = pswl_pkg::MAIN_FLOOR
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           wide_i,
    input  logic [A_W-1:0] swallow_i,
    input  logic [B_W-1:0] main_i,
    output logic           div_o,
    output logic           cfg_err_o
);
    logic [A_W-1:0] a_eff;
    logic [B_W-1:0] b_eff;
    logic           bad;
    logic           run;
    logic           hi;
    logic           plus1;
    logic           tick;

    pswl_cfg_clamp #(.A_W(A_W), .B_W(B_W), .FLOOR(FLOOR)) u_clamp (
        .swallow_i (swallow_i),
        .main_i    (main_i),
        .a_eff_o   (a_eff),
        .b_eff_o   (b_eff),
        .bad_o     (bad)
    );

    pswl_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_presc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .hi_i    (hi),
        .plus1_i (plus1),
        .tick_o  (tick)
    );

    pswl_swallow_main #(.A_W(A_W), .B_W(B_W)) u_count (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .a_eff_i   (a_eff),
        .b_eff_i   (b_eff),
        .hi_cfg_i  (wide_i),
        .err_cfg_i (bad),
        .run_o     (run),
        .hi_o      (hi),
        .plus1_o   (plus1),
        .div_o     (div_o),
        .err_o     (cfg_err_o)
    );

    assert_err_on_boundary_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cfg_err_o) |-> (div_o || !$past(run)));

    assert_idle_quiet_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run |-> (!div_o && !cfg_err_o));
endmodule

// File: tb/tb_pswl_divider.sv
module tb_pswl_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide = 1'b0;
    logic [4:0]  a = 5'd0;
    logic [12:0] b = 13'd0;
    logic        div;
    logic        err;

    int compared = 0;
    int mismatched = 0;
    logic prev_div = 1'b0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    pswl_divider dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wide_i    (wide),
        .swallow_i (a),
        .main_i    (b),
        .div_o     (div),
        .cfg_err_o (err)
    );

    function automatic int exp_n(input bit w, input int av, input int bv);
        int p, be, ae;
        p  = w ? 32 : 8;
        be = (bv < 3) ? 3 : bv;
        ae = (av > be) ? be : av;
        return p * be + ae;
    endfunction

    function automatic bit exp_err(input int av, input int bv);
        return (bv < 3) || (av > bv);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic gap(output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!div && g < 100000);
    endtask

    // R3: pulse width checked on every observed pulse
    always @(negedge clk) begin
        if (rst_n && div) begin
            chk(!prev_div, "R3 width", 2, 1);
        end
        prev_div = div;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int g;
        int prev_n;
        bit prev_e;
        int cur_n;
        bit cur_e;
        string tag;

        wide = 1'b0; a = 5'd5; b = 13'd10;
        repeat (3) @(negedge clk);
        chk(div == 1'b0, "R1 div in reset", int'(div), 0);
        chk(err == 1'b0, "R1 err in reset", int'(err), 0);
        rst_n = 1'b1;
        prev_n = exp_n(1'b0, 5, 10);
        prev_e = 1'b0;
        gap(g);
        chk(g == prev_n + 1, "R4 first pulse", g, prev_n + 1);
        chk(err == prev_e, "R1 err after load", int'(err), int'(prev_e));

        for (int pass = 0; pass < 2; pass++) begin
            for (int bi = 0; bi < 45; bi++) begin
                for (int ai = 0; ai < 32; ai++) begin
                    bit w;
                    if (pass == 0) begin
                        if (bi > 12 || ai > 15) continue;
                        w = 1'b0;
                    end else begin
                        if (!((bi == 3 || bi == 5 || bi == 17 || bi == 31 || bi == 40) &&
                              (ai == 0 || ai == 7 || ai == 31))) continue;
                        w = (bi != 31);
                    end
                    wide = w; a = 5'(ai); b = 13'(bi);
                    cur_n = exp_n(w, ai, bi);
                    cur_e = exp_err(ai, bi);
                    @(negedge clk);
                    chk(err == prev_e, "R8 err held mid-cycle", int'(err), int'(prev_e));
                    gap(g);
                    chk(g + 1 == prev_n, "R7 old ratio kept", g + 1, prev_n);
                    tag = (bi < 3) ? "R6 err flag" : ((ai > bi) ? "R5 err flag" : "R8 err flag");
                    chk(err == cur_e, tag, int'(err), int'(cur_e));
                    gap(g);
                    tag = (bi < 3) ? "R6 clamped ratio" : ((ai > bi) ? "R5 clamped ratio" : "R2 ratio");
                    chk(g == cur_n, tag, g, cur_n);
                    prev_n = cur_n;
                    prev_e = cur_e;
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule